// File: doc/BRIEF.md
# Compare-Action Timer Channel

This block is one channel of a general-purpose timer. A down-counter runs from a programmable load value. It drives one output pin, using either an eight-way action code or a PWM scheme. In PWM mode the pin is cleared when the counter equals a match value. The counter stops at zero, and that cycle is the time-out. The block raises a time-out interrupt pulse, which can be masked. It also raises a PWM edge interrupt pulse, which is gated by an enable and an edge selector.

In compare mode, the action code can preset the pin at the moment the channel is enabled. It then applies a separate action at each time-out. The load and match values are taken from input ports. They are committed either every cycle or only at a time-out, where a time-out commit is also made when the channel is enabled. A stall input freezes the whole channel. All registered state resets to zero.

Top module: `cmp_timer_unit`

## Requirements
- R1: With `act_code` = 0 and `pwm_mode` = 0, the pin keeps its level on every cycle, including enable and time-out.
- R2: In compare mode (`pwm_mode` = 0), a time-out changes the pin as follows: code 1 toggles it, code 2 clears it, code 3 sets it. The new level is seen one cycle after the time-out cycle.
- R3: In compare mode, codes 4 and 5 drive the pin high (code 4) or low (code 5) on the edge where `en` is first sampled high. Both codes then toggle the pin at each time-out.
- R4: In compare mode, code 6 presets the pin high on enable and clears it at time-out. Code 7 presets the pin low on enable and sets it at time-out.
- R5: With `upd_on_tmo` = 0, the active load and match values follow `load_val` and `match_val` every unstalled cycle. A reload uses the `load_val` that is present in the time-out cycle.
- R6: With `upd_on_tmo` = 1, new load and match values are committed only in a time-out cycle or on the enable edge. In between, changes to the inputs have no effect on the period.
- R7: The enable edge loads the counter with the committed load value. Each later running cycle decrements it. The cycle in which it reads zero is the time-out, and the next cycle reloads it. The period is therefore load+1 cycles.
- R8: `tmo_irq` pulses for one cycle, one cycle after each time-out cycle. It stays low if `tmo_mask` was 1 in the time-out cycle.
- R9: In PWM mode, the pin is cleared when a running counter equals the match value. With `pwm_force_hi` = 1 the pin is set at each time-out. With `pwm_force_hi` = 0 it is set one running cycle later, on the reload. A set wins over a clear.
- R10: `pwm_irq` pulses in the cycle in which the pin shows an edge of the selected kind. `pwm_edge_sel` selects the edge: 0 = rising, 1 = falling, 2 or 3 = both. The pulse occurs only if `pwm_mode` = 1 and `pwm_irq_en` = 1.
- R11: While `stall` is high, the counter, the pin, the pending enable edge and the register commits all hold. No time-out occurs.
- R12: After reset, `pin_out`, `tmo_irq` and `pwm_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Channel enable |
| stall | input | 1 | Freeze the channel |
| act_code | input | 3 | Compare action code (0..7) |
| upd_on_tmo | input | 1 | 1: commit load/match only at time-out or enable |
| pwm_mode | input | 1 | 1: PWM output scheme |
| pwm_force_hi | input | 1 | PWM: set pin at time-out instead of at reload |
| tmo_mask | input | 1 | Suppress time-out interrupt |
| pwm_irq_en | input | 1 | Enable PWM edge interrupt |
| pwm_edge_sel | input | 2 | PWM interrupt edge: 0 rise, 1 fall, 2/3 both |
| load_val | input | CNT_W | Load (period) value |
| match_val | input | CNT_W | PWM match value |
| pin_out | output | 1 | Compare/PWM output pin |
| tmo_irq | output | 1 | Time-out interrupt pulse |
| pwm_irq | output | 1 | PWM edge interrupt pulse |

## Verification
A wrong counter or committed load value shows up as time-out pulses and pin changes that occur too early or too late. The error is visible within one period of the faulty count. A wrong action decode or preset shows on `pin_out` one cycle after the enable edge or the time-out. A faulty stall or commit gate appears as a shifted period one time-out after the stimulus. Because of this, the bench compares all three outputs against its model on every cycle.

// File: rtl/cmp_tmr_pkg.sv
package cmp_tmr_pkg;

    typedef enum logic [2:0] {
        ACT_NONE      = 3'd0,
        ACT_TOG       = 3'd1,
        ACT_CLR       = 3'd2,
        ACT_SET       = 3'd3,
        ACT_HI_TOG    = 3'd4,
        ACT_LO_TOG    = 3'd5,
        ACT_HI_CLR    = 3'd6,
        ACT_LO_SET    = 3'd7
    } act_e;

    typedef enum logic [1:0] {
        EDGE_RISE  = 2'd0,
        EDGE_FALL  = 2'd1,
        EDGE_BOTH  = 2'd2,
        EDGE_BOTH2 = 2'd3
    } edge_e;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic             upd_on_tmo,
    input  logic             tmo,
    input  logic             rise,
    input  logic [CNT_W-1:0] load_in,
    input  logic [CNT_W-1:0] match_in,
    output logic [CNT_W-1:0] load_q,
    output logic [CNT_W-1:0] match_q,
    output logic [CNT_W-1:0] load_nxt
);

    typedef struct packed {
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] match;
    } regs_t;

    regs_t st_d, st_q;
    logic  commit;

    always_comb begin
        st_d   = st_q;
        commit = !stall && (!upd_on_tmo || tmo || rise);
        if (commit) begin
            st_d.load  = load_in;
            st_d.match = match_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_q   = st_q.load;
    assign match_q  = st_q.match;
    assign load_nxt = st_d.load;

    // Deferred mode: nothing moves without a time-out or enable edge
    p_hold_shadow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_on_tmo && !tmo && !rise) |=> ($stable(load_q) && $stable(match_q)));

    p_stall_regs_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(load_q));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             stall,
    input  logic [CNT_W-1:0] load_nxt,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             rise,
    output logic             tmo,
    output logic             reload
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en;
        logic             rl;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        rise = en && !st_q.en && !stall;
        run  = en && st_q.en && !stall;
        tmo  = run && (st_q.cnt == '0);
        if (!stall) begin
            st_d.en = en;
            st_d.rl = tmo;
        end
        if (rise || tmo)  st_d.cnt = load_nxt;
        else if (run)     st_d.cnt = st_q.cnt - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt    = st_q.cnt;
    assign reload = st_q.rl;

    p_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != '0) |=> (cnt == $past(cnt) - ONE));

    p_stall_cnt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(cnt));

    p_rl_follows_tmo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && !stall) |=> reload);

endmodule

// File: rtl/tmr_pin_ctl.sv
module tmr_pin_ctl
    import cmp_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       act_code,
    input  logic             pwm_mode,
    input  logic             pwm_force_hi,
    input  logic             rise,
    input  logic             tmo,
    input  logic             run,
    input  logic             reload,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] match_q,
    output logic             pin_q,
    output logic             pin_d
);

    typedef struct packed {
        logic pin;
    } pin_t;

    pin_t st_d, st_q;
    act_e act;
    logic pwm_set, pwm_clr;

    always_comb begin
        st_d    = st_q;
        act     = act_e'(act_code);
        pwm_set = (tmo && pwm_force_hi) || (reload && run && !pwm_force_hi);
        pwm_clr = run && (cnt == match_q);
        if (pwm_mode) begin
            if (pwm_set)      st_d.pin = 1'b1;
            else if (pwm_clr) st_d.pin = 1'b0;
        end else if (rise) begin
            case (act)
                ACT_HI_TOG, ACT_HI_CLR: st_d.pin = 1'b1;
                ACT_LO_TOG, ACT_LO_SET: st_d.pin = 1'b0;
                default:                st_d.pin = st_q.pin;
            endcase
        end else if (tmo) begin
            case (act)
                ACT_TOG, ACT_HI_TOG, ACT_LO_TOG: st_d.pin = !st_q.pin;
                ACT_CLR, ACT_HI_CLR:             st_d.pin = 1'b0;
                ACT_SET, ACT_LO_SET:             st_d.pin = 1'b1;
                default:                         st_d.pin = st_q.pin;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin_q = st_q.pin;
    assign pin_d = st_d.pin;

    p_code0_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (act_code == 3'd0 && !pwm_mode) |=> $stable(pin_q));

    p_preset_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !pwm_mode && (act_code == 3'd4 || act_code == 3'd6)) |=> pin_q);

    p_force_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && pwm_mode && pwm_force_hi) |=> pin_q);

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq
    import cmp_tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tmo,
    input  logic       tmo_mask,
    input  logic       pwm_mode,
    input  logic       pwm_irq_en,
    input  logic [1:0] pwm_edge_sel,
    input  logic       pin_q,
    input  logic       pin_d,
    output logic       tmo_irq,
    output logic       pwm_irq
);

    typedef struct packed {
        logic tmo;
        logic pwm;
    } irq_t;

    irq_t  st_d, st_q;
    edge_e sel;
    logic  up, dn, hit;

    always_comb begin
        sel = edge_e'(pwm_edge_sel);
        up  = pin_d && !pin_q;
        dn  = !pin_d && pin_q;
        case (sel)
            EDGE_RISE: hit = up;
            EDGE_FALL: hit = dn;
            default:   hit = up || dn;
        endcase
        st_d.tmo = tmo && !tmo_mask;
        st_d.pwm = pwm_mode && pwm_irq_en && hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tmo_irq = st_q.tmo;
    assign pwm_irq = st_q.pwm;

    p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_mask |=> !tmo_irq);

    p_pwm_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_mode || !pwm_irq_en) |=> !pwm_irq);

    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_irq |=> !tmo_irq);

endmodule

// File: rtl/cmp_timer_unit.sv
module cmp_timer_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             stall,
    input  logic [2:0]       act_code,
    input  logic             upd_on_tmo,
    input  logic             pwm_mode,
    input  logic             pwm_force_hi,
    input  logic             tmo_mask,
    input  logic             pwm_irq_en,
    input  logic [1:0]       pwm_edge_sel,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] match_val,
    output logic             pin_out,
    output logic             tmo_irq,
    output logic             pwm_irq
);

    logic [CNT_W-1:0] load_q, match_q, load_nxt, cnt;
    logic             run, rise, tmo, reload, pin_q, pin_d;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .stall(stall), .upd_on_tmo(upd_on_tmo),
        .tmo(tmo), .rise(rise), .load_in(load_val), .match_in(match_val),
        .load_q(load_q), .match_q(match_q), .load_nxt(load_nxt)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en), .stall(stall), .load_nxt(load_nxt),
        .cnt(cnt), .run(run), .rise(rise), .tmo(tmo), .reload(reload)
    );

    tmr_pin_ctl #(.CNT_W(CNT_W)) u_pin (
        .clk(clk), .rst_n(rst_n), .act_code(act_code), .pwm_mode(pwm_mode),
        .pwm_force_hi(pwm_force_hi), .rise(rise), .tmo(tmo), .run(run),
        .reload(reload), .cnt(cnt), .match_q(match_q),
        .pin_q(pin_q), .pin_d(pin_d)
    );

    tmr_irq u_irq (
        .clk(clk), .rst_n(rst_n), .tmo(tmo), .tmo_mask(tmo_mask),
        .pwm_mode(pwm_mode), .pwm_irq_en(pwm_irq_en), .pwm_edge_sel(pwm_edge_sel),
        .pin_q(pin_q), .pin_d(pin_d), .tmo_irq(tmo_irq), .pwm_irq(pwm_irq)
    );

    assign pin_out = pin_q;

    // load_q only feeds the deferred-commit check
    p_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && !upd_on_tmo) |=> (cnt == $past(load_val)));

    p_reload_val_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && upd_on_tmo) |=> (load_q == $past(load_val)));

endmodule

// File: tb/test_cmp_timer_unit.sv
module test_cmp_timer_unit;

    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 0, stall = 0, upd_on_tmo = 0, pwm_mode = 0, pwm_force_hi = 0;
    logic tmo_mask = 0, pwm_irq_en = 0;
    logic [2:0] act_code = 0;
    logic [1:0] pwm_edge_sel = 0;
    logic [W-1:0] load_val = 0, match_val = 0;
    logic pin_out, tmo_irq, pwm_irq;

    int checks = 0, failures = 0;
    bit done = 0;
    string req = "R12";

    // reference state
    int  m_cnt = 0, m_load = 0, m_match = 0;
    bit  m_en = 0, m_rl = 0, m_pin = 0, m_ti = 0, m_pi = 0;

    always #5 clk = ~clk;

    cmp_timer_unit #(.CNT_W(W)) i_cmp_timer_unit (
        .clk(clk), .rst_n(rst_n), .en(en), .stall(stall), .act_code(act_code),
        .upd_on_tmo(upd_on_tmo), .pwm_mode(pwm_mode), .pwm_force_hi(pwm_force_hi),
        .tmo_mask(tmo_mask), .pwm_irq_en(pwm_irq_en), .pwm_edge_sel(pwm_edge_sel),
        .load_val(load_val), .match_val(match_val),
        .pin_out(pin_out), .tmo_irq(tmo_irq), .pwm_irq(pwm_irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_load = 0; m_match = 0;
            m_en = 0; m_rl = 0; m_pin = 0; m_ti = 0; m_pi = 0;
        end else begin
            automatic bit up  = en && !m_en && !stall;
            automatic bit go  = en && m_en && !stall;
            automatic bit hit = go && (m_cnt == 0);
            automatic bit np  = m_pin;
            automatic bit ed;
            if (!stall && (!upd_on_tmo || hit || up)) begin
                m_load = int'(load_val);
                m_match = int'(match_val);
            end
            if (pwm_mode) begin
                if ((hit && pwm_force_hi) || (m_rl && go && !pwm_force_hi)) np = 1;
                else if (go && m_cnt == m_match) np = 0;
            end else if (up) begin
                if (act_code == 4 || act_code == 6) np = 1;
                if (act_code == 5 || act_code == 7) np = 0;
            end else if (hit) begin
                if (act_code == 1 || act_code == 4 || act_code == 5) np = !m_pin;
                if (act_code == 2 || act_code == 6) np = 0;
                if (act_code == 3 || act_code == 7) np = 1;
            end
            case (pwm_edge_sel)
                2'd0:    ed = np && !m_pin;
                2'd1:    ed = !np && m_pin;
                default: ed = np != m_pin;
            endcase
            m_pi = pwm_mode && pwm_irq_en && ed;
            m_ti = hit && !tmo_mask;
            m_pin = np;
            if (up || hit) m_cnt = m_load;
            else if (go)   m_cnt = m_cnt - 1;
            if (!stall) begin
                m_en = en;
                m_rl = hit;
            end
        end
    end

    task automatic cmp_out();
        checks++;
        if (pin_out !== m_pin || tmo_irq !== m_ti || pwm_irq !== m_pi) begin
            failures++;
            $display("FAIL %s t=%0t pin/tmo/pwm actual=%b%b%b expected=%b%b%b",
                     req, $time, pin_out, tmo_irq, pwm_irq, m_pin, m_ti, m_pi);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmp_out();
        end
    endtask

    task automatic restart(logic [2:0] code, int n);
        en = 0; step(1);
        act_code = code; en = 1; step(n);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        step(2);
        rst_n = 1; step(2);
        // R2 / R7: period load+1 with toggle, clear, set
        req = "R2"; load_val = 3;
        restart(3'd1, 14);
        restart(3'd2, 8);
        restart(3'd3, 8);
        restart(3'd1, 6);
        // R3 / R4: presets then time-out action
        req = "R3"; restart(3'd4, 10); restart(3'd5, 10);
        req = "R4"; restart(3'd6, 10); restart(3'd7, 10);
        restart(3'd6, 3);
        // R1: code 0 holds
        req = "R1"; restart(3'd0, 12);
        // R5: immediate update
        req = "R5"; act_code = 3'd1; load_val = 5; step(3);
        load_val = 2; step(9); load_val = 6; step(10);
        // R6: deferred update, commit on enable
        req = "R6"; upd_on_tmo = 1; load_val = 4; step(12);
        load_val = 1; step(3); load_val = 7; step(12);
        en = 0; load_val = 2; step(3); en = 1; step(10);
        upd_on_tmo = 0;
        // R8: interrupt masking
        req = "R8"; load_val = 3; tmo_mask = 1; step(10);
        tmo_mask = 0; step(10);
        // R9: PWM, legacy and forced set
        req = "R9"; pwm_mode = 1; load_val = 9; match_val = 4; restart(3'd0, 25);
        pwm_force_hi = 1; step(25);
        match_val = 7; step(12);
        // R10: PWM edge interrupts
        req = "R10"; pwm_irq_en = 1;
        for (int s = 0; s < 4; s++) begin
            pwm_edge_sel = 2'(s); step(22);
        end
        pwm_irq_en = 0; step(12);
        // R11: stall freeze
        req = "R11"; pwm_irq_en = 1; pwm_edge_sel = 2;
        stall = 1; step(5); stall = 0; step(4);
        stall = 1; step(3); stall = 0; step(12);
        pwm_mode = 0; act_code = 3'd1; load_val = 2;
        en = 0; step(1); stall = 1; en = 1; step(3); stall = 0; step(8);
        stall = 1; step(2); stall = 0; step(6);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule